// File: doc/BRIEF.md
# Per-Channel Signalling Debouncer

This block cleans up the four robbed-bit signalling values (A, B, C, D) of 24 voice channels before they reach a status stream. An upstream extractor delivers one strobe per channel with a channel index and a 4-bit ABCD value. The block accepts a new value only after that value has stayed unchanged for a set number of 8 kHz frames. Each accepted value is stored in a per-channel status array, which a read port exposes.

All per-channel state is kept in one state memory: the value waiting for acceptance, the accepted value and a stability counter. Every frame tick starts a sweep that visits each channel once and advances its counter. Updates share the same read-modify-write pipeline as the sweep and take precedence over it. When a global bypass control is high, each update goes straight into the status array with no waiting.

Top module: `sig_debounce`

## Requirements
- R1: After reset, every channel reads 0000 on the status port and every channel's stability counter starts from zero.
- R2: The read port returns the accepted value of channel `rd_chan` on `rd_abcd` two clock edges after `rd_chan` is presented. An index of 24 or more reads 0000.
- R3: With bypass low, an update whose value differs from the channel's waiting value makes it the new waiting value. It restarts that channel's counter at zero and leaves the accepted value unchanged.
- R4: A waiting value becomes the accepted value on the 48th frame tick after its last restart, and not on any earlier tick.
- R5: With bypass low, an update that repeats the channel's current waiting value does not restart the counter.
- R6: With bypass high, an update makes the value both accepted and waiting at once, and saturates the counter. It is readable within four cycles, with no frame tick needed.
- R7: An update whose channel index is 24 or more changes no channel's state.
- R8: An update on the same cycle as a sweep step wins, and the sweep resumes afterwards without skipping a channel. A frame tick that arrives while a sweep is still running is held and served by one more full sweep.
- R9: Updates to the same channel on consecutive cycles take effect in order: each one sees the result of the one before it.
- R10: Channels are independent: an update or acceptance on one channel never changes another channel's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per 125 us frame |
| bypass | input | 1 | High: updates are accepted immediately |
| upd_valid | input | 1 | Signalling update strobe |
| upd_chan | input | 5 | Channel index of the update |
| upd_abcd | input | 4 | ABCD signalling value, A in bit 3, D in bit 0 |
| rd_chan | input | 5 | Channel index to read from the status array |
| rd_abcd | output | 4 | Accepted ABCD value of the channel read, two edges later |

## Verification
On every cycle, the assertions check the per-operation rules of the shared pipeline. A changed value restarts the counter and keeps the accepted value. A repeated value leaves the entry untouched. A bypass update lands as accepted. An accepted value changes only on a sweep step that reaches the limit. They also check that operations stay within the channel range and that a pending sweep position is frozen while an update holds the pipeline. Only the bench's scenarios can show the timing that results: exact acceptance on the 48th tick and not the 47th, a held tick turning into a full extra sweep, and back-to-back updates being forwarded correctly. The same goes for status reads across all 24 channels in reset, bypass and out-of-range cases.

// File: rtl/sigdb_pkg.sv
package sigdb_pkg;

  // Kind of operation travelling through the shared read-modify-write pipeline
  typedef enum logic {
    OP_UPD  = 1'b0,   // signalling update from the extractor
    OP_TICK = 1'b1    // one sweep step triggered by a frame tick
  } sigdb_op_e;

endpackage

// File: rtl/sigdb_ram.sv
// Simple dual-port memory: one synchronous write port, one registered read port.
// Read-first on a same-address collision. No reset, so it maps onto block RAM.
module sigdb_ram #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 24,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rq
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end

endmodule

// File: rtl/sigdb_sched.sv
// Chooses one operation per cycle for the state pipeline. A valid in-range
// update always wins; otherwise the running sweep issues its next channel.
module sigdb_sched
  import sigdb_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int SIG_W  = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic             upd_valid,
  input  logic [CH_W-1:0]  upd_chan,
  input  logic [SIG_W-1:0] upd_abcd,
  output logic             op_valid,
  output sigdb_op_e        op_kind,
  output logic [CH_W-1:0]  op_chan,
  output logic [SIG_W-1:0] op_val
);

  localparam logic [CH_W:0]   NCH_EXT = (CH_W+1)'(NUM_CH);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic            sweep_on;
  logic            tick_held;
  logic [CH_W-1:0] ptr;
  logic            upd_ok;
  logic            sweep_step;

  // Out-of-range channels are dropped here, before they reach the memory
  assign upd_ok     = upd_valid && ({1'b0, upd_chan} < NCH_EXT);
  assign sweep_step = sweep_on && !upd_ok;

  always_comb begin
    op_valid = upd_ok || sweep_on;
    op_kind  = upd_ok ? OP_UPD : OP_TICK;
    op_chan  = upd_ok ? upd_chan : ptr;
    op_val   = upd_abcd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_on  <= 1'b0;
      tick_held <= 1'b0;
      ptr       <= '0;
    end else if (!sweep_on) begin
      if (frame_tick || tick_held) begin
        sweep_on  <= 1'b1;
        tick_held <= 1'b0;
        ptr       <= '0;
      end
    end else begin
      if (frame_tick) tick_held <= 1'b1;
      if (sweep_step) begin
        if (ptr == LAST_CH) begin
          ptr       <= '0;
          sweep_on  <= tick_held || frame_tick;
          tick_held <= 1'b0;
        end else begin
          ptr <= ptr + CH_W'(1);
        end
      end
    end
  end

  // R7: nothing outside the channel range ever reaches the state memory
  a_r7_op_in_range: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> ({1'b0, op_chan} < NCH_EXT))
    else $error("operation issued for channel out of range");

  // R8: an update that pre-empts the sweep freezes the sweep position
  a_r8_sweep_frozen: assert property (@(posedge clk) disable iff (rst)
    (sweep_on && upd_ok) |=> (ptr == $past(ptr)))
    else $error("sweep pointer moved while an update held the pipeline");

  // R8: the sweep pointer stays inside the channel range
  a_r8_ptr_range: assert property (@(posedge clk) disable iff (rst)
    sweep_on |-> ({1'b0, ptr} < NCH_EXT))
    else $error("sweep pointer out of range");

endmodule

// File: rtl/sigdb_next.sv
// Next-state function for one channel entry: waiting value, accepted value
// and stability counter.
module sigdb_next
  import sigdb_pkg::*;
#(
  parameter int SIG_W         = 4,
  parameter int STABLE_FRAMES = 48,
  localparam int CNT_W        = $clog2(STABLE_FRAMES + 1)
) (
  input  sigdb_op_e        kind,
  input  logic             byp,
  input  logic [SIG_W-1:0] val,
  input  logic [SIG_W-1:0] o_acc,
  input  logic [SIG_W-1:0] o_pend,
  input  logic [CNT_W-1:0] o_cnt,
  output logic [SIG_W-1:0] n_acc,
  output logic [SIG_W-1:0] n_pend,
  output logic [CNT_W-1:0] n_cnt
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(STABLE_FRAMES);

  always_comb begin
    n_acc  = o_acc;
    n_pend = o_pend;
    n_cnt  = o_cnt;
    if (kind == OP_UPD) begin
      if (byp) begin
        n_acc  = val;
        n_pend = val;
        n_cnt  = LIM;
      end else if (val != o_pend) begin
        n_pend = val;
        n_cnt  = '0;
      end
    end else if (o_cnt < LIM) begin
      n_cnt = o_cnt + CNT_W'(1);
      if (n_cnt == LIM) n_acc = o_pend;
    end
  end

endmodule

// File: rtl/sig_debounce.sv
// Per-channel ABCD signalling debouncer, all channels sharing one state memory.
module sig_debounce
  import sigdb_pkg::*;
#(
  parameter int NUM_CH        = 24,
  parameter int SIG_W         = 4,
  parameter int STABLE_FRAMES = 48,
  localparam int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W        = $clog2(STABLE_FRAMES + 1),
  localparam int ENT_W        = 2 * SIG_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic             bypass,
  input  logic             upd_valid,
  input  logic [CH_W-1:0]  upd_chan,
  input  logic [SIG_W-1:0] upd_abcd,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [SIG_W-1:0] rd_abcd
);

  localparam logic [CH_W:0]    NCH_EXT = (CH_W+1)'(NUM_CH);
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(STABLE_FRAMES);

  // ---------------- stage 0: operation select ----------------
  logic             op_valid;
  sigdb_op_e        op_kind;
  logic [CH_W-1:0]  op_chan;
  logic [SIG_W-1:0] op_val;

  sigdb_sched #(.NUM_CH(NUM_CH), .SIG_W(SIG_W)) u_sched (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .upd_valid  (upd_valid),
    .upd_chan   (upd_chan),
    .upd_abcd   (upd_abcd),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_chan    (op_chan),
    .op_val     (op_val)
  );

  // ---------------- state memory ----------------
  logic             wr_en;
  logic [CH_W-1:0]  wr_chan;
  logic [ENT_W-1:0] wr_ent;
  logic [ENT_W-1:0] st_q;

  sigdb_ram #(.WIDTH(ENT_W), .DEPTH(NUM_CH)) u_state_ram (
    .clk (clk),
    .we  (wr_en),
    .wa  (wr_chan),
    .wd  (wr_ent),
    .ra  (op_chan),
    .rq  (st_q)
  );

  // ---------------- stage 1: modify and write back ----------------
  logic             s1_valid;
  sigdb_op_e        s1_kind;
  logic [CH_W-1:0]  s1_chan;
  logic [SIG_W-1:0] s1_val;
  logic             s1_byp;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= OP_UPD;
      s1_chan  <= '0;
      s1_val   <= '0;
      s1_byp   <= 1'b0;
    end else begin
      s1_valid <= op_valid;
      s1_kind  <= op_kind;
      s1_chan  <= op_chan;
      s1_val   <= op_val;
      s1_byp   <= bypass;
    end
  end

  // Entries never written since reset read as all-zero; the write of the
  // previous cycle is forwarded because the memory returns old data.
  logic [NUM_CH-1:0] ent_live;
  logic              last_wr_valid;
  logic [CH_W-1:0]   last_wr_chan;
  logic [ENT_W-1:0]  last_wr_ent;
  logic              fwd_hit;
  logic [ENT_W-1:0]  old_ent;

  assign fwd_hit = last_wr_valid && (last_wr_chan == s1_chan);

  always_comb begin
    if (fwd_hit)                old_ent = last_wr_ent;
    else if (ent_live[s1_chan]) old_ent = st_q;
    else                        old_ent = '0;
  end

  logic [SIG_W-1:0] old_acc, old_pend, new_acc, new_pend;
  logic [CNT_W-1:0] old_cnt, new_cnt;

  assign {old_acc, old_pend, old_cnt} = old_ent;

  sigdb_next #(.SIG_W(SIG_W), .STABLE_FRAMES(STABLE_FRAMES)) u_next (
    .kind   (s1_kind),
    .byp    (s1_byp),
    .val    (s1_val),
    .o_acc  (old_acc),
    .o_pend (old_pend),
    .o_cnt  (old_cnt),
    .n_acc  (new_acc),
    .n_pend (new_pend),
    .n_cnt  (new_cnt)
  );

  assign wr_en   = s1_valid;
  assign wr_chan = s1_chan;
  assign wr_ent  = {new_acc, new_pend, new_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_live      <= '0;
      last_wr_valid <= 1'b0;
      last_wr_chan  <= '0;
      last_wr_ent   <= '0;
    end else begin
      if (wr_en) ent_live[wr_chan] <= 1'b1;
      last_wr_valid <= wr_en;
      last_wr_chan  <= wr_chan;
      last_wr_ent   <= wr_ent;
    end
  end

  // ---------------- status array and read port ----------------
  logic             rd_ok;
  logic [CH_W-1:0]  rd_idx;
  logic             rd_gate;
  logic [SIG_W-1:0] stat_q;

  assign rd_ok  = ({1'b0, rd_chan} < NCH_EXT);
  assign rd_idx = rd_ok ? rd_chan : '0;

  sigdb_ram #(.WIDTH(SIG_W), .DEPTH(NUM_CH)) u_status_ram (
    .clk (clk),
    .we  (wr_en),
    .wa  (wr_chan),
    .wd  (new_acc),
    .ra  (rd_idx),
    .rq  (stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_gate <= 1'b0;
      rd_abcd <= '0;
    end else begin
      rd_gate <= rd_ok && ent_live[rd_idx];
      rd_abcd <= rd_gate ? stat_q : '0;
    end
  end

  // ---------------- assertions ----------------
  // R3: a changed value restarts the counter and keeps the accepted value
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_kind == OP_UPD && !s1_byp && s1_val != old_pend)
    |=> (last_wr_ent[CNT_W-1:0] == '0) &&
        (last_wr_ent[ENT_W-1 -: SIG_W] == $past(old_acc)))
    else $error("changed value did not restart the channel");

  // R5: a repeated value leaves the entry untouched
  a_r5_repeat_hold: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_kind == OP_UPD && !s1_byp && s1_val == old_pend)
    |=> (last_wr_ent == $past(old_ent)))
    else $error("repeated value altered the channel entry");

  // R6: a bypass update lands as the accepted value with a saturated counter
  a_r6_bypass_accept: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_kind == OP_UPD && s1_byp)
    |=> (last_wr_ent[ENT_W-1 -: SIG_W] == $past(s1_val)) &&
        (last_wr_ent[CNT_W-1:0] == LIM))
    else $error("bypass update not accepted at once");

  // R4: outside bypass, acceptance happens only on a sweep step reaching the limit
  a_r4_accept_at_limit: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !(s1_kind == OP_UPD && s1_byp) && new_acc != old_acc)
    |-> (s1_kind == OP_TICK && new_cnt == LIM && old_cnt != LIM))
    else $error("accepted value changed before the stability limit");

endmodule

// File: tb/sig_debounce_bench.sv
`timescale 1ns/1ps
module sig_debounce_bench;

  localparam int NCH = 24;
  localparam int LIM = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic       bypass = 1'b0;
  logic       upd_valid = 1'b0;
  logic [4:0] upd_chan = '0;
  logic [3:0] upd_abcd = '0;
  logic [4:0] rd_chan = '0;
  logic [3:0] rd_abcd;

  always #2.5 clk = ~clk;

  sig_debounce u_sig_debounce (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .bypass     (bypass),
    .upd_valid  (upd_valid),
    .upd_chan   (upd_chan),
    .upd_abcd   (upd_abcd),
    .rd_chan    (rd_chan),
    .rd_abcd    (rd_abcd)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int m_pend [NCH];
  int m_acc  [NCH];
  int m_cnt  [NCH];

  function automatic void model_upd(int ch, int v, bit byp);
    if (ch >= NCH) return;          // R7: out-of-range index is dropped
    if (byp) begin                  // R6
      m_pend[ch] = v; m_acc[ch] = v; m_cnt[ch] = LIM;
    end else if (v != m_pend[ch]) begin   // R3
      m_pend[ch] = v; m_cnt[ch] = 0;
    end                             // R5: same value keeps counting
  endfunction

  function automatic void model_tick();
    for (int c = 0; c < NCH; c++) begin
      if (m_cnt[c] < LIM) begin
        m_cnt[c]++;
        if (m_cnt[c] == LIM) m_acc[c] = m_pend[c];   // R4
      end
    end
  endfunction

  task automatic check(input string req, input int got, input int exp, input int ch);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s ch=%0d actual=%0h expected=%0h", req, ch, got, exp);
    end
  endtask

  task automatic read_chk(input int ch, input int exp, input string req);
    @(negedge clk);
    rd_chan = ch[4:0];
    @(negedge clk);
    @(negedge clk);
    check(req, int'(rd_abcd), exp, ch);
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) read_chk(c, m_acc[c], req);
  endtask

  task automatic upd(input int ch, input int v);
    @(negedge clk);
    upd_valid = 1'b1; upd_chan = ch[4:0]; upd_abcd = v[3:0];
    model_upd(ch, v, bypass);
    @(negedge clk);
    upd_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // two updates to one channel on consecutive cycles (R9)
  task automatic upd_pair(input int ch, input int v0, input int v1);
    @(negedge clk);
    upd_valid = 1'b1; upd_chan = ch[4:0]; upd_abcd = v0[3:0];
    model_upd(ch, v0, bypass);
    @(negedge clk);
    upd_abcd = v1[3:0];
    model_upd(ch, v1, bypass);
    @(negedge clk);
    upd_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick(input int gap);
    @(negedge clk);
    frame_tick = 1'b1;
    model_tick();
    @(negedge clk);
    frame_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick(30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_pend[c] = 0; m_acc[c] = 0; m_cnt[c] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state; R2: out-of-range read gives zero
    check_all("R1");
    read_chk(30, 0, "R2");

    // R10/R3: distinct value on every channel, then count to the limit
    for (int c = 0; c < NCH; c++) upd(c, (c * 7 + 3) % 16);
    ticks(LIM - 1);
    check_all("R4 before limit");
    ticks(1);
    check_all("R4 at limit R10");

    // R5 on channel 5, R3 restart on channel 6
    upd(5, 9); upd(6, 4);
    ticks(20);
    upd(5, 9); upd(6, 2);
    ticks(28);
    read_chk(5, 9, "R5");
    check_all("R3 restart held");
    ticks(20);
    read_chk(6, 2, "R3");
    check_all("R3 after restart");

    // R6: bypass updates visible without ticks
    bypass = 1'b1;
    for (int c = 0; c < NCH; c += 3) upd(c, 15 - (c % 16));
    check_all("R6");
    // R7: out-of-range updates in bypass change nothing
    for (int c = NCH; c < 32; c++) upd(c, 10);
    check_all("R7");
    read_chk(NCH, 0, "R2 R7");

    // R9: back-to-back updates, bypass and not
    upd_pair(11, 5, 9);
    read_chk(11, 9, "R9 bypass");
    bypass = 1'b0;
    upd(10, 7);
    ticks(40);
    upd_pair(10, 3, 7);
    ticks(8);
    check_all("R9 no early accept");
    ticks(40);
    read_chk(10, 7, "R9");
    check_all("R9 settle");

    // R8: update inside a sweep, and a tick held during a sweep
    upd(12, 6);
    ticks(LIM - 2);
    tick(3);
    tick(60);
    read_chk(12, 6, "R8 held tick");
    bypass = 1'b1;
    @(negedge clk);
    frame_tick = 1'b1;
    model_tick();
    @(negedge clk);
    frame_tick = 1'b0;
    repeat (3) @(negedge clk);
    upd(2, 13);
    repeat (40) @(negedge clk);
    bypass = 1'b0;
    check_all("R8 priority");
    upd(20, 1);
    ticks(LIM);
    check_all("R8 sweep intact");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule